// File: doc/BRIEF.md
# Software-Driven TAP Bit-Bang Register

This block lets host software run a JTAG test access port one edge at a time. The host writes a small control word that sets the levels of the TRST, TMS and TDO lines toward the target. It reads the same word back to poll the TDI line from the target. Every host access also moves the test clock. A write pulls TCK low and a read pushes it high, so a write followed by a read makes one full TCK period. The new TMS and TDO levels are set up on the falling edge. TDI is captured on the rising edge.

The pins only follow the register while the discrete-mode input is high. In any other mode an automatic sequencer owns the port. The register stays writable and readable then, but the TCK, TMS, TDO and TRST levels this block presents do not move. The block also gives a registered copy of the mode input, which the surrounding logic uses as the select of its pin multiplexer.

Top module: `tap_bitbang_reg`

## Requirements
- R1: After reset: `tck_o` is 1; `tms_o`, `tdo_o` and `trst_o` are 0; `host_rdata` is 0x00; `bb_active` is 0.
- R2: A write in discrete mode sets `trst_o` to data bit 3, `tms_o` to data bit 2 and `tdo_o` to data bit 0. The levels are visible from the clock edge that samples the write.
- R3: A write in discrete mode drives `tck_o` to 0 on that same edge.
- R4: A read in discrete mode drives `tck_o` to 1 on the edge that samples it. A read never changes `trst_o`, `tms_o` or `tdo_o`.
- R5: On a read, `host_rdata` becomes {4'b0000, stored bit 3, stored bit 2, TDI, stored bit 0}. TDI is the level of `tdi_i` at the sampling edge. Bit 1 of any write is discarded, and bits 7:4 always read 0.
- R6: With discrete mode low, writes and reads still update and return the register, but `tck_o`, `tms_o`, `tdo_o` and `trst_o` keep their levels.
- R7: An access is the rising edge of (`host_sel` AND strobe). A strobe held high for several cycles counts as one access, and later changes of `tdi_i` during the hold are not captured.
- R8: When read and write strobes rise in the same cycle, the write is performed and the read is dropped: `host_rdata` is unchanged.
- R9: With `host_sel` low, strobes have no effect on any output.
- R10: `bb_active` equals `disc_mode` delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 1 | Host selects this register |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| disc_mode | input | 1 | Discrete (software) control mode enable |
| tdi_i | input | 1 | TDI line from the target |
| host_rdata | output | 8 | Registered read data |
| tck_o | output | 1 | Test clock level |
| tms_o | output | 1 | Test mode select level |
| tdo_o | output | 1 | Test data level toward the target |
| trst_o | output | 1 | Test reset level |
| bb_active | output | 1 | Registered mode select for the pin multiplexer |

## Verification
Every result of this block is due exactly one clock edge after the strobe is first seen high. This covers the pin levels, the TCK edge, the captured read word and the mode select. No result takes longer. The bench raises strobes on a falling clock edge and reads the outputs on the next falling edge, one full edge after the sampling edge. For held strobes, the bench keeps sampling at each later falling edge to show that nothing moves again. For accesses outside discrete mode and with the select low, the bench reads back both the pins and the register contents through a read.

// File: rtl/tapbb_pkg.sv
// Package: shared constants and types for the TAP bit-bang register.
// Assumes: a host data bus of at least CTRL_W bits.
package tapbb_pkg;
    // Width of the control word that carries meaning.
    localparam int CTRL_W   = 4;
    // Bit positions inside the control word; host software depends on them.
    localparam int TRST_POS = 3;
    localparam int TMS_POS  = 2;
    localparam int TDI_POS  = 1;
    localparam int TDO_POS  = 0;

    // Levels presented toward the target.
    typedef struct packed {
        logic tck;
        logic tms;
        logic tdo;
        logic trst;
    } tap_pins_t;

    // Reset levels of the pins: clock idle high, target held in reset.
    localparam tap_pins_t PINS_RESET = '{tck: 1'b1, tms: 1'b0, tdo: 1'b0, trst: 1'b0};
endpackage

// File: rtl/tapbb_access_detect.sv
// Module: turns level strobes into single-cycle access events.
// An access is the rising edge of (select AND strobe). A write that rises
// in the same cycle as a read wins, and that read is dropped.
// Assumes: strobes are synchronous to clk.
module tapbb_access_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic rd,
    input  logic wr,
    output logic wr_evt,
    output logic rd_evt
);
    logic rd_lvl;
    logic wr_lvl;
    logic rd_q;
    logic wr_q;

    // Qualified strobe levels.
    always_comb begin
        rd_lvl = sel & rd;
        wr_lvl = sel & wr;
    end

    // Remember the previous strobe levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= 1'b0;
            wr_q <= 1'b0;
        end else begin
            rd_q <= rd_lvl;
            wr_q <= wr_lvl;
        end
    end

    // Rising-edge events, write having priority over a simultaneous read.
    always_comb begin
        wr_evt = wr_lvl & ~wr_q;
        rd_evt = rd_lvl & ~rd_q & ~wr_lvl;
    end
endmodule

// File: rtl/tapbb_ctrl_reg.sv
// Module: holds the control word and builds the registered read word.
// The stored bits are the TRST, TMS and TDO positions. The TDI position is
// not stored; it is the live TDI level captured at the read event.
// Assumes: at most one of wr_evt and rd_evt is high in a cycle.
module tapbb_ctrl_reg
    import tapbb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_evt,
    input  logic              rd_evt,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tdi,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [CTRL_W-1:0] STORE_MASK = CTRL_W'(~(1 << TDI_POS));

    logic [DATA_W-1:0] rd_word;

    // Store the writable bits of the control word on each write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_evt) begin
            ctrl_q <= wdata[CTRL_W-1:0] & STORE_MASK;
        end
    end

    // Assemble the read word; bits above the control field read as zero.
    for (genvar b = 0; b < DATA_W; b++) begin : g_rd_bit
        if (b == TDI_POS) begin : g_tdi
            assign rd_word[b] = tdi;
        end else if (b < CTRL_W) begin : g_ctrl
            assign rd_word[b] = ctrl_q[b];
        end else begin : g_zero
            assign rd_word[b] = 1'b0;
        end
    end

    // Capture the read word on each read event; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_evt) begin
            rdata <= rd_word;
        end
    end
endmodule

// File: rtl/tapbb_pin_drive.sv
// Module: produces the pin levels and the test clock in discrete mode.
// A write sets TRST, TMS and TDO from the write data and drops TCK. A read
// raises TCK. Outside discrete mode the pins hold their levels.
// Assumes: the write data is the same word stored by the control register.
module tapbb_pin_drive
    import tapbb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode,
    input  logic              wr_evt,
    input  logic              rd_evt,
    input  logic [DATA_W-1:0] wdata,
    output tap_pins_t         pins,
    output logic              active
);
    tap_pins_t pins_nxt;

    // Next pin levels from the current access and mode.
    always_comb begin
        pins_nxt = pins;
        if (mode && wr_evt) begin
            pins_nxt.tck  = 1'b0;
            pins_nxt.tms  = wdata[TMS_POS];
            pins_nxt.tdo  = wdata[TDO_POS];
            pins_nxt.trst = wdata[TRST_POS];
        end else if (mode && rd_evt) begin
            pins_nxt.tck  = 1'b1;
        end
    end

    // Pin level registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pins <= PINS_RESET;
        end else begin
            pins <= pins_nxt;
        end
    end

    // Registered mode select for the external pin multiplexer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
        end else begin
            active <= mode;
        end
    end
endmodule

// File: rtl/tap_bitbang_reg.sv
// Module: top of the software-driven TAP bit-bang register.
// Detects host accesses, stores the control word, drives the pin levels
// and test clock in discrete mode and returns the read word with TDI.
// Assumes: host strobes are synchronous to clk; the sequencer pin mux
// lives outside and is steered by bb_active.
module tap_bitbang_reg
    import tapbb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              disc_mode,
    input  logic              tdi_i,
    output logic [DATA_W-1:0] host_rdata,
    output logic              tck_o,
    output logic              tms_o,
    output logic              tdo_o,
    output logic              trst_o,
    output logic              bb_active
);
    logic              wr_evt;
    logic              rd_evt;
    logic [CTRL_W-1:0] ctrl_q;
    tap_pins_t         pins;

    tapbb_access_detect u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (host_sel),
        .rd     (host_rd),
        .wr     (host_wr),
        .wr_evt (wr_evt),
        .rd_evt (rd_evt)
    );

    tapbb_ctrl_reg #(.DATA_W(DATA_W)) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_evt (wr_evt),
        .rd_evt (rd_evt),
        .wdata  (host_wdata),
        .tdi    (tdi_i),
        .ctrl_q (ctrl_q),
        .rdata  (host_rdata)
    );

    tapbb_pin_drive #(.DATA_W(DATA_W)) u_pins (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (disc_mode),
        .wr_evt (wr_evt),
        .rd_evt (rd_evt),
        .wdata  (host_wdata),
        .pins   (pins),
        .active (bb_active)
    );

    // Unpack the pin struct onto the ports.
    always_comb begin
        tck_o  = pins.tck;
        tms_o  = pins.tms;
        tdo_o  = pins.tdo;
        trst_o = pins.trst;
    end

    // The stored word reaches the ports only through reads.
    logic unused_ctrl;
    assign unused_ctrl = ^ctrl_q;
endmodule

// File: rtl/tap_bitbang_reg_chk.sv
// Module: temporal checks on the ports of tap_bitbang_reg, bound to it.
// Assumes: the default data width of 8.
module tap_bitbang_reg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_sel,
    input logic       host_rd,
    input logic       host_wr,
    input logic [7:0] host_wdata,
    input logic       disc_mode,
    input logic       tdi_i,
    input logic [7:0] host_rdata,
    input logic       tck_o,
    input logic       tms_o,
    input logic       tdo_o,
    input logic       trst_o,
    input logic       bb_active
);
    // R3
    wr_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(host_sel && host_wr) && disc_mode) |=> !tck_o);

    // R2
    wr_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(host_sel && host_wr) && disc_mode) |=>
            (trst_o == $past(host_wdata[3]) && tms_o == $past(host_wdata[2])
             && tdo_o == $past(host_wdata[0])));

    // R4
    rd_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(host_sel && host_rd) && !(host_sel && host_wr) && disc_mode) |=> tck_o);

    // R5
    rd_tdi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(host_sel && host_rd) && !(host_sel && host_wr)) |=>
            (host_rdata[1] == $past(tdi_i)));

    // R5
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdata[7:4] == 4'h0);

    // R6
    pins_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !disc_mode |=> $stable({tck_o, tms_o, tdo_o, trst_o}));

    // R9
    nosel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_sel |=> $stable({host_rdata, tck_o, tms_o, tdo_o, trst_o}));

    // R10
    mode_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (bb_active == $past(disc_mode)));
endmodule

bind tap_bitbang_reg tap_bitbang_reg_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_sel   (host_sel),
    .host_rd    (host_rd),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .disc_mode  (disc_mode),
    .tdi_i      (tdi_i),
    .host_rdata (host_rdata),
    .tck_o      (tck_o),
    .tms_o      (tms_o),
    .tdo_o      (tdo_o),
    .trst_o     (trst_o),
    .bb_active  (bb_active)
);

// File: tb/tap_bitbang_reg_tb.sv
module tap_bitbang_reg_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_sel = 1'b0;
    logic       host_rd = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic       disc_mode = 1'b0;
    logic       tdi_i = 1'b0;
    logic [7:0] host_rdata;
    logic       tck_o, tms_o, tdo_o, trst_o, bb_active;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #2 clk = ~clk;

    tap_bitbang_reg u_dut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_rd(host_rd),
        .host_wr(host_wr), .host_wdata(host_wdata), .disc_mode(disc_mode),
        .tdi_i(tdi_i), .host_rdata(host_rdata), .tck_o(tck_o), .tms_o(tms_o),
        .tdo_o(tdo_o), .trst_o(trst_o), .bb_active(bb_active)
    );

    // Vector: {mode, is_read, wdata[7:0], tdi, pins {tck,tms,tdo,trst}, rdata[7:0]}
    localparam int NV = 13;
    localparam logic [22:0] VEC [NV] = '{
        {1'b1, 1'b0, 8'h0C, 1'b0, 4'b0101, 8'h00},
        {1'b1, 1'b1, 8'h00, 1'b1, 4'b1101, 8'h0E},
        {1'b1, 1'b0, 8'h09, 1'b0, 4'b0011, 8'h0E},
        {1'b1, 1'b1, 8'h00, 1'b0, 4'b1011, 8'h09},
        {1'b1, 1'b0, 8'hFF, 1'b0, 4'b0111, 8'h09},
        {1'b1, 1'b1, 8'h00, 1'b1, 4'b1111, 8'h0F},
        {1'b0, 1'b0, 8'h00, 1'b0, 4'b1111, 8'h0F},
        {1'b0, 1'b1, 8'h00, 1'b0, 4'b1111, 8'h00},
        {1'b0, 1'b0, 8'h05, 1'b0, 4'b1111, 8'h00},
        {1'b0, 1'b1, 8'h00, 1'b1, 4'b1111, 8'h07},
        {1'b1, 1'b1, 8'h00, 1'b0, 4'b1111, 8'h05},
        {1'b1, 1'b0, 8'h02, 1'b0, 4'b0000, 8'h05},
        {1'b1, 1'b1, 8'h00, 1'b0, 4'b1000, 8'h00}
    };

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] obs();
        return {tck_o, tms_o, tdo_o, trst_o, host_rdata};
    endfunction

    // One access: strobe raised at a falling edge, outputs sampled one edge later.
    task automatic access(input logic sel, input logic rd, input logic wr,
                          input logic [7:0] d, input logic tdi);
        @(negedge clk);
        host_sel = sel; host_rd = rd; host_wr = wr; host_wdata = d; tdi_i = tdi;
        @(negedge clk);
        host_sel = 1'b0; host_rd = 1'b0; host_wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", obs(), {4'b1000, 8'h00});
        check("R1 bb_active", {11'd0, bb_active}, 12'd0);

        // R2..R6 table walk
        for (int i = 0; i < NV; i++) begin
            disc_mode = VEC[i][22];
            access(1'b1, VEC[i][21], !VEC[i][21], VEC[i][20:13], VEC[i][12]);
            check($sformatf("R2/R3/R4/R5/R6 row %0d", i), obs(), VEC[i][11:0]);
        end

        // R10 mode select follows one clock later
        @(negedge clk); disc_mode = 1'b0;
        @(negedge clk);
        check("R10 low", {11'd0, bb_active}, 12'd0);
        disc_mode = 1'b1;
        check("R10 not yet", {11'd0, bb_active}, 12'd0);
        @(negedge clk);
        check("R10 high", {11'd0, bb_active}, 12'd1);

        // Bit-banged TAP reset: five TMS-high clocks, TCK toggles per access (R3, R4)
        for (int k = 0; k < 5; k++) begin
            access(1'b1, 1'b0, 1'b1, 8'h0C, 1'b0);
            check("R3 tapreset fall", obs() >> 8, 12'h5);
            access(1'b1, 1'b1, 1'b0, 8'h00, 1'b0);
            check("R4 tapreset rise", obs() >> 8, 12'hD);
        end

        // One-bit shift: TDO=1, capture TDI=1 (R2, R5)
        access(1'b1, 1'b0, 1'b1, 8'h09, 1'b0);
        check("R2 shift setup", obs(), {4'b0011, 8'h0C});
        access(1'b1, 1'b1, 1'b0, 8'h00, 1'b1);
        check("R5 shift capture", obs(), {4'b1011, 8'h0B});

        // R7 held read: TDI change during hold is not captured, TCK stays high
        access(1'b1, 1'b0, 1'b1, 8'h04, 1'b0);
        @(negedge clk);
        host_sel = 1'b1; host_rd = 1'b1; tdi_i = 1'b1;
        @(negedge clk);
        check("R7 first", obs(), {4'b1100, 8'h06});
        tdi_i = 1'b0;
        @(negedge clk);
        check("R7 held", obs(), {4'b1100, 8'h06});
        // R7 held write while read still high: write rises, fires once
        host_wr = 1'b1; host_wdata = 8'h01;
        @(negedge clk);
        check("R7 wr during rd", obs(), {4'b0010, 8'h06});
        host_wdata = 8'h08;
        @(negedge clk);
        check("R7 wr held", obs(), {4'b0010, 8'h06});
        host_sel = 1'b0; host_rd = 1'b0; host_wr = 1'b0;

        // R8 simultaneous rd and wr: write wins, read dropped
        access(1'b1, 1'b1, 1'b0, 8'h00, 1'b0);
        check("R8 pre", obs(), {4'b1010, 8'h01});
        access(1'b1, 1'b1, 1'b1, 8'h0C, 1'b1);
        check("R8 both", obs(), {4'b0101, 8'h01});
        access(1'b1, 1'b1, 1'b0, 8'h00, 1'b0);
        check("R8 stored", obs(), {4'b1101, 8'h0C});

        // R9 strobes without select do nothing
        access(1'b0, 1'b0, 1'b1, 8'h01, 1'b1);
        check("R9 wr nosel", obs(), {4'b1101, 8'h0C});
        access(1'b0, 1'b1, 1'b0, 8'h00, 1'b1);
        check("R9 rd nosel", obs(), {4'b1101, 8'h0C});
        access(1'b1, 1'b1, 1'b0, 8'h00, 1'b0);
        check("R9 reg kept", obs(), {4'b1101, 8'h0C});

        // R5 bit 1 and upper bits of a write are discarded
        access(1'b1, 1'b0, 1'b1, 8'hF2, 1'b0);
        access(1'b1, 1'b1, 1'b0, 8'h00, 1'b0);
        check("R5 masked", obs(), {4'b1000, 8'h00});

        // R1 reset again from a non-reset state
        access(1'b1, 1'b0, 1'b1, 8'h0D, 1'b0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 re-reset", obs(), {4'b1000, 8'h00});

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule